// File: doc/BRIEF.md
# Switch-Change Interrupt and Wake Controller

This block watches a vector of switch contact states and raises an active-low interrupt whenever an enabled input changes state while the block is in normal mode. The interrupt is modelled as an open-drain drive: the block only ever pulls the shared interrupt line low, and otherwise releases it to the external pullup.

The interrupt ties into serial chip-select framing. When chip select falls, the current interrupt state is captured into a status bit that a host can read back during the frame. When chip select rises, the interrupt is released. The release is held off if a further switch change was seen while chip select was low, so no event is lost between a read and its acknowledge.

A two-state mode tracker moves the block into sleep on request. In sleep, switch changes raise no interrupt. A falling edge on chip select, or a falling edge sensed on the shared interrupt line, returns the block to normal mode.

Top module: `swint_wake_ctrl`

## Requirements
- R1: In normal mode, a change on any enabled switch input sets `irq_pull` high on the following clock edge, and it stays high until a chip-select rising edge releases it.
- R2: A change on an input whose `sw_en` bit is 0 does not affect `irq_pull`.
- R3: On the cycle after a chip-select falling edge (`cs_n` 1 to 0), `irq_status` equals the value `irq_pull` had in the cycle of that edge. It holds that value until the next falling edge.
- R4: A chip-select rising edge clears `irq_pull` when no enabled change was seen while chip select was low.
- R5: An enabled change seen while `cs_n` is low keeps `irq_pull` high across the following chip-select rising edge.
- R6: An enabled change in the same cycle as the chip-select rising edge keeps `irq_pull` high.
- R7: In normal mode, `sleep_req` high moves the block to sleep (`mode_sleep` = 1) on the next edge.
- R8: In sleep, switch changes never set `irq_pull`. A change made during sleep does not raise an interrupt after wake-up.
- R9: In sleep, a falling edge on `irq_line` returns the block to normal mode on the next edge.
- R10: In sleep, a falling edge on `cs_n` returns the block to normal mode on the next edge.
- R11: Reset puts the block in normal mode with `irq_pull` = 0 and `irq_status` = 0. The reference switch vector is taken from the inputs, so a change in the first cycle after reset release raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_in | input | NUM_SW | Current switch states (1 = closed) |
| sw_en | input | NUM_SW | Per-input change-detect enable |
| cs_n | input | 1 | Serial chip select, active low, already synchronous to clk |
| irq_line | input | 1 | Sensed level of the shared interrupt line |
| sleep_req | input | 1 | Request to enter sleep mode |
| irq_pull | output | 1 | 1 = pull the interrupt line low |
| irq_status | output | 1 | Interrupt state captured at chip-select fall |
| mode_sleep | output | 1 | 1 = sleep mode, 0 = normal mode |

## Verification
The properties assume that `sw_in`, `cs_n` and `irq_line` are already synchronous to `clk` and free of bounce, so that every edge they see is a real event lasting at least one cycle. The stimulus changes every input only on the falling clock edge and holds it for a whole cycle. It keeps `irq_line` high except for deliberate one-cycle wake pulses, so the edge-based wake properties see clean transitions.

// File: rtl/swint_pkg.sv
package swint_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_SLEEP  = 1'b1
  } swint_mode_e;
endpackage

// File: rtl/swint_change_det.sv
module swint_change_det #(
  parameter int unsigned NUM_SW = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SW-1:0] sw_in,
  input  logic [NUM_SW-1:0] sw_en,
  input  logic              detect_en,
  output logic              change,
  output logic              armed
);
  logic [NUM_SW-1:0] prev_q;
  logic [NUM_SW-1:0] hit;
  logic              armed_q;

  // reference copy follows the inputs every cycle, reset included
  always_ff @(posedge clk) begin
    prev_q <= sw_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar i = 0; i < NUM_SW; i++) begin : g_bit
    assign hit[i] = (sw_in[i] ^ prev_q[i]) & sw_en[i];
  end

  assign change = armed_q & detect_en & (|hit);
  assign armed  = armed_q;
endmodule

// File: rtl/swint_frame_edges.sv
module swint_frame_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic irq_line,
  output logic cs_fall,
  output logic cs_rise,
  output logic line_fall
);
  logic cs_q, line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      line_q <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      line_q <= irq_line;
    end
  end

  assign cs_fall   = cs_q & ~cs_n;
  assign cs_rise   = ~cs_q & cs_n;
  assign line_fall = line_q & ~irq_line;
endmodule

// File: rtl/swint_irq_ctrl.sv
module swint_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic change,
  input  logic cs_n,
  input  logic cs_fall,
  input  logic cs_rise,
  output logic irq_pull,
  output logic irq_status
);
  logic pull_q, pull_d;
  logic pend_q, pend_d;
  logic stat_q, stat_d;

  always_comb begin
    // release on frame end only if nothing arrived during the frame
    if (cs_rise) pull_d = pend_q | change;
    else         pull_d = pull_q | change;

    if (cs_fall)    pend_d = change;
    else if (!cs_n) pend_d = pend_q | change;
    else            pend_d = 1'b0;

    stat_d = cs_fall ? pull_q : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b0;
      pend_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      pull_q <= pull_d;
      pend_q <= pend_d;
      if (cs_fall) stat_q <= stat_d;
    end
  end

  assign irq_pull   = pull_q;
  assign irq_status = stat_q;
endmodule

// File: rtl/swint_mode_fsm.sv
module swint_mode_fsm
  import swint_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_req,
  input  logic        wake,
  output swint_mode_e mode
);
  swint_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_NORMAL: if (sleep_req) mode_d = MODE_SLEEP;
      MODE_SLEEP:  if (wake)      mode_d = MODE_NORMAL;
      default:                    mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NORMAL;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/swint_wake_ctrl.sv
module swint_wake_ctrl
  import swint_pkg::*;
#(
  parameter int unsigned NUM_SW = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SW-1:0] sw_in,
  input  logic [NUM_SW-1:0] sw_en,
  input  logic              cs_n,
  input  logic              irq_line,
  input  logic              sleep_req,
  output logic              irq_pull,
  output logic              irq_status,
  output logic              mode_sleep
);
  swint_mode_e mode;
  logic        change, armed;
  logic        cs_fall, cs_rise, line_fall;

  swint_change_det #(.NUM_SW(NUM_SW)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_in     (sw_in),
    .sw_en     (sw_en),
    .detect_en (mode == MODE_NORMAL),
    .change    (change),
    .armed     (armed)
  );

  swint_frame_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .irq_line  (irq_line),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .line_fall (line_fall)
  );

  swint_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .change     (change),
    .cs_n       (cs_n),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .irq_pull   (irq_pull),
    .irq_status (irq_status)
  );

  swint_mode_fsm u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .wake      (cs_fall | line_fall),
    .mode      (mode)
  );

  assign mode_sleep = (mode == MODE_SLEEP);
endmodule

// File: rtl/swint_wake_chk.sv
module swint_wake_chk #(
  parameter int unsigned NUM_SW = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SW-1:0] sw_in,
  input logic [NUM_SW-1:0] sw_en,
  input logic              cs_n,
  input logic              irq_line,
  input logic              sleep_req,
  input logic              armed,
  input logic              irq_pull,
  input logic              irq_status,
  input logic              mode_sleep
);
  // R1
  enabled_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !mode_sleep && |((sw_in ^ $past(sw_in)) & sw_en) |=> irq_pull);

  // R3
  status_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> irq_status == $past(irq_pull));

  // R7
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sleep && sleep_req |=> mode_sleep);

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sleep && !irq_pull |=> !irq_pull);

  // R9
  line_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sleep && $fell(irq_line) |=> !mode_sleep);

  // R10
  cs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sleep && $fell(cs_n) |=> !mode_sleep);
endmodule

bind swint_wake_ctrl swint_wake_chk #(.NUM_SW(NUM_SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_in      (sw_in),
  .sw_en      (sw_en),
  .cs_n       (cs_n),
  .irq_line   (irq_line),
  .sleep_req  (sleep_req),
  .armed      (armed),
  .irq_pull   (irq_pull),
  .irq_status (irq_status),
  .mode_sleep (mode_sleep)
);

// File: tb/swint_wake_ctrl_test.sv
module swint_wake_ctrl_test;
  localparam int unsigned NUM_SW = 22;

  typedef struct {
    string tag;
    bit    pull;
    bit    stat;
    bit    sleep;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NUM_SW-1:0] sw_in;
  logic [NUM_SW-1:0] sw_en;
  logic              cs_n, irq_line, sleep_req;
  logic              irq_pull, irq_status, mode_sleep;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  swint_wake_ctrl #(.NUM_SW(NUM_SW)) uut (
    .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .sw_en(sw_en), .cs_n(cs_n),
    .irq_line(irq_line), .sleep_req(sleep_req), .irq_pull(irq_pull),
    .irq_status(irq_status), .mode_sleep(mode_sleep)
  );

  task automatic chk(string tag, string what, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // driver: inputs already set at this negedge; queue what the next edge yields
  task automatic step(string tag, bit ep, bit es, bit esl);
    exp_t e;
    e.tag = tag; e.pull = ep; e.stat = es; e.sleep = esl;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "irq_pull",   irq_pull,   e.pull);
      chk(e.tag, "irq_status", irq_status, e.stat);
      chk(e.tag, "mode_sleep", mode_sleep, e.sleep);
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_in = '0; sw_en = 22'h3;
    cs_n = 1'b1; irq_line = 1'b1; sleep_req = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state while held
    chk("R11", "irq_pull",   irq_pull,   1'b0);
    chk("R11", "irq_status", irq_status, 1'b0);
    chk("R11", "mode_sleep", mode_sleep, 1'b0);
    // R11: release and change an enabled input at once: no interrupt
    rst_n = 1'b1; sw_in[0] = 1'b1;
    step("R11", 0, 0, 0);
    step("R11", 0, 0, 0);
    // R1: enabled change, sticky
    sw_in[0] = 1'b0; step("R1", 1, 0, 0);
    step("R1", 1, 0, 0);
    // R3: capture at frame start
    cs_n = 1'b0; step("R3", 1, 1, 0);
    // R4: clean frame end releases
    cs_n = 1'b1; step("R4", 0, 1, 0);
    // R2: disabled bit 5 ignored
    sw_in[5] = 1'b1; step("R2", 0, 1, 0);
    cs_n = 1'b0; step("R3", 0, 0, 0);
    // R5: change inside frame holds past frame end
    sw_in[1] = 1'b1; step("R5", 1, 0, 0);
    cs_n = 1'b1; step("R5", 1, 0, 0);
    cs_n = 1'b0; step("R3", 1, 1, 0);
    // R6: change in the rising-edge cycle
    cs_n = 1'b1; sw_in[0] = 1'b1; step("R6", 1, 1, 0);
    cs_n = 1'b0; step("R6", 1, 1, 0);
    cs_n = 1'b1; step("R4", 0, 1, 0);
    // R7: enter sleep
    sleep_req = 1'b1; step("R7", 0, 1, 1);
    sleep_req = 1'b0;
    // R8: change during sleep gives no interrupt
    sw_in[1] = 1'b0; step("R8", 0, 1, 1);
    // R9: interrupt line falling edge wakes
    irq_line = 1'b0; step("R9", 0, 1, 0);
    irq_line = 1'b1; step("R8", 0, 1, 0);
    sleep_req = 1'b1; step("R7", 0, 1, 1);
    // R10: chip-select falling edge wakes
    sleep_req = 1'b0; cs_n = 1'b0; step("R10", 0, 0, 0);
    cs_n = 1'b1; step("R10", 0, 0, 0);
    // R1 again after wake
    sw_in[1] = 1'b1; step("R1", 1, 0, 0);
    repeat (2) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard actual=%0d expected=0 items left", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule